// File: doc/BRIEF.md
# Configurable Registered ROM Front End

This block is a read-only style memory array behind an edge-triggered output register. A load port fills the array and writes a small configuration byte. Three bits of that byte set the behaviour of the read path:

- whether the read address passes straight through or is held by an address latch;
- which level of the latch-enable input counts as active;
- whether the output enable acts combinationally or is sampled at the clock edge.

The configuration byte sits one location above the last array word. With `ADDR_W` set to 15 the array holds 32768 bytes at 0x0000 to 0x7FFF, and the configuration byte is at 0x8000. The default parameter value builds a 256-word array, with the configuration byte at 0x100. The data outputs would be tri-state lines in a package. Here they are modelled as a data bus that reads zero while disabled, together with a valid flag.

Top module: `rrom_top`

## Requirements
- R1: A load write (`ldWe` high, `ldAddr` below 2**ADDR_W) stores `ldData` into that array word at the rising edge. At every rising edge the output register loads the array word at the effective address. With outputs enabled, `dataOut` shows that word from just after the edge.
- R2: A load write to `ldAddr` = 2**ADDR_W updates the configuration from the edge of the write onward. Bit 0 = 1 selects latched address mode. Bit 1 = 1 makes latch enable active low. Bit 2 = 1 selects clocked enable. Bits 3 to 7 are ignored, so writing 0xF8 leaves the default behaviour in place.
- R3: With configuration bit 0 = 0, the effective address is `addrIn`, and `aleIn` has no effect on the data read.
- R4: With bit 0 = 1 and bit 1 = 0, the effective address is `addrIn` whenever `aleIn` is high. While `aleIn` is low, it is the `addrIn` value seen at the last rising edge at which `aleIn` was high.
- R5: With bit 0 = 1 and bit 1 = 1, the behaviour of R4 holds with the latch-enable level inverted (low = active).
- R6: With bit 2 = 1, `outValid` takes the value of `!enIn` sampled at each rising edge, and does not change between edges.
- R7: With bit 2 = 0, `outValid` equals `!enIn` combinationally (enable active low).
- R8: While `outValid` is low, `dataOut` is zero.
- R9: Synchronous active-high `rst` clears the output register to zero, clears the clocked enable state to disabled, and sets all configuration bits to zero.
- R10: Load writes to addresses above 2**ADDR_W change neither the array nor the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | Read address |
| aleIn | input | 1 | Address latch enable, polarity set by the configuration |
| enIn | input | 1 | Output enable, active low |
| ldWe | input | 1 | Load port write strobe |
| ldAddr | input | ADDR_W+1 | Load port address; the top value 2**ADDR_W selects the configuration byte |
| ldData | input | DATA_W | Load port write data |
| dataOut | output | DATA_W | Registered read data, zero while disabled |
| outValid | output | 1 | High while the outputs are driven |

## Verification
The bench holds the latch enable inactive across several edges while changing the address. A design that kept following the address, or that captured the wrong value at the release, shows the wrong word. The same sequence is repeated with the polarity bit set, which exposes a design that ignores the polarity bit.

In clocked-enable mode, the enable pin is changed between edges. A design that leaks the pin through combinationally turns the outputs on early. In combinational mode, the same change must act at once.

Further checks cover three more failure types:
- A write of only the unused configuration bits, and writes above the configuration address. A design that decodes too few address bits or too many data bits would switch mode or corrupt an aliased array word.
- A reset taken while in clocked mode. This catches a design that fails to restore the default mode.

// File: rtl/rrom_pkg.sv
package rrom_pkg;

  // Configuration byte bits [2:0]; the packed order places addrLatched at bit 0.
  typedef struct packed {
    logic syncEnable;   // bit 2: enable sampled on the clock edge
    logic aleLow;       // bit 1: latch enable active low
    logic addrLatched;  // bit 0: address held by the latch
  } cfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic arrayWr;      // write ldData into the array
    logic holdLoad;     // capture addrIn into the hold register
    logic selLive;      // read from addrIn instead of the hold register
  } strobe_t;

endpackage

// File: rtl/rrom_ctrl.sv
module rrom_ctrl
  import rrom_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aleIn,
  input  logic              enIn,
  input  logic              ldWe,
  input  logic [ADDR_W:0]   ldAddr,
  input  logic [2:0]        cfgData,
  output strobe_t           strobe,
  output logic              outValid
);

  localparam logic [ADDR_W:0] CfgAddr = {1'b1, {ADDR_W{1'b0}}};

  cfg_t cfgReg;
  logic enSync;
  logic aleActive;
  logic cfgWr;

  always_comb begin
    aleActive       = cfgReg.aleLow ? !aleIn : aleIn;
    cfgWr           = ldWe && (ldAddr == CfgAddr);
    strobe.arrayWr  = ldWe && !ldAddr[ADDR_W];
    strobe.selLive  = !cfgReg.addrLatched || aleActive;
    strobe.holdLoad = cfgReg.addrLatched && aleActive;
    outValid        = cfgReg.syncEnable ? enSync : !enIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgReg <= '0;
      enSync <= 1'b0;
    end else begin
      if (cfgWr) cfgReg <= cfg_t'(cfgData);
      enSync <= !enIn;
    end
  end

  // R6: in clocked mode the valid flag reflects the pin sampled one edge earlier
  assert_sync_follow_R6: assert property (@(posedge clk) disable iff (rst)
    (cfgReg.syncEnable && $past(cfgReg.syncEnable) && !$past(rst))
      |-> (outValid == !$past(enIn)));

  // R7: in combinational mode the valid flag tracks the pin
  assert_async_follow_R7: assert property (@(posedge clk) disable iff (rst)
    !cfgReg.syncEnable |-> (outValid == !enIn));

  // R9: the configuration returns to default after reset
  assert_cfg_default_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfgReg == '0));

  // R3: transparent mode always reads the live address
  assert_transparent_live_R3: assert property (@(posedge clk) disable iff (rst)
    !cfgReg.addrLatched |-> strobe.selLive);

endmodule

// File: rtl/rrom_datapath.sv
module rrom_datapath
  import rrom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEn,
  output logic [DATA_W-1:0] dataOut
);

  localparam int Depth = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [Depth];
  logic [ADDR_W-1:0] holdAddr;
  logic [ADDR_W-1:0] effAddr;
  logic [DATA_W-1:0] qReg;

  always_comb begin
    effAddr = strobe.selLive ? addrIn : holdAddr;
    dataOut = outEn ? qReg : '0;
  end

  always_ff @(posedge clk) begin
    if (strobe.arrayWr) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qReg     <= '0;
      holdAddr <= '0;
    end else begin
      qReg <= mem[effAddr];
      if (strobe.holdLoad) holdAddr <= addrIn;
    end
  end

  // R9: the output register is cleared after reset
  assert_q_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (qReg == '0));

  // R8: disabled outputs read zero
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !outEn |-> (dataOut == '0));

endmodule

// File: rtl/rrom_top.sv
module rrom_top
  import rrom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              aleIn,
  input  logic              enIn,
  input  logic              ldWe,
  input  logic [ADDR_W:0]   ldAddr,
  input  logic [DATA_W-1:0] ldData,
  output logic [DATA_W-1:0] dataOut,
  output logic              outValid
);

  strobe_t strobe;

  rrom_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .aleIn    (aleIn),
    .enIn     (enIn),
    .ldWe     (ldWe),
    .ldAddr   (ldAddr),
    .cfgData  (ldData[2:0]),
    .strobe   (strobe),
    .outValid (outValid)
  );

  rrom_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .addrIn  (addrIn),
    .wrAddr  (ldAddr[ADDR_W-1:0]),
    .wrData  (ldData),
    .outEn   (outValid),
    .dataOut (dataOut)
  );

endmodule

// File: tb/sim_rrom_top.sv
`timescale 1ns/1ps
module sim_rrom_top;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [AW:0] CFG = 9'h100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic aleIn = 1'b0;
  logic enIn = 1'b0;
  logic ldWe = 1'b0;
  logic [AW:0] ldAddr = '0;
  logic [DW-1:0] ldData = '0;
  logic [DW-1:0] dataOut;
  logic outValid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rrom_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .addrIn(addrIn), .aleIn(aleIn), .enIn(enIn),
    .ldWe(ldWe), .ldAddr(ldAddr), .ldData(ldData),
    .dataOut(dataOut), .outValid(outValid)
  );

  // Row layout: {ale, en, expValid, addr[7:0]}
  localparam logic [10:0] Vecs [8] = '{
    {1'b0, 1'b0, 1'b1, 8'h00},
    {1'b1, 1'b0, 1'b1, 8'h01},
    {1'b0, 1'b0, 1'b1, 8'h7F},
    {1'b1, 1'b1, 1'b0, 8'h80},
    {1'b0, 1'b0, 1'b1, 8'hFF},
    {1'b1, 1'b0, 1'b1, 8'hA5},
    {1'b0, 1'b1, 1'b0, 8'h3C},
    {1'b1, 1'b0, 1'b1, 8'h5A}
  };

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) ^ (a >> 3));
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [7:0] expD, logic expV);
    total++;
    if (dataOut !== expD || outValid !== expV) begin
      bad++;
      $display("FAIL %s: dataOut=%h outValid=%b expected dataOut=%h outValid=%b",
               tag, dataOut, outValid, expD, expV);
    end
  endtask

  task automatic load(logic [AW:0] a, logic [7:0] d);
    ldWe = 1'b1; ldAddr = a; ldData = d;
    step();
    ldWe = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finishRun();
  end

  initial begin
    // R9: reset state, default combinational enable, enable low
    step(); step();
    check("R9 reset clears output register", 8'h00, 1'b1);
    rst = 1'b0;

    // R1: fill the array
    for (int i = 0; i < 2 ** AW; i++) load(9'(i), pat(i));

    // R1 R3 R8: vector table in transparent combinational mode, ALE toggling
    for (int v = 0; v < 8; v++) begin
      aleIn  = Vecs[v][10];
      enIn   = Vecs[v][9];
      addrIn = Vecs[v][7:0];
      step();
      check("R1 R3 R8 table read", Vecs[v][8] ? pat(int'(Vecs[v][7:0])) : 8'h00, Vecs[v][8]);
    end
    enIn = 1'b0;

    // R10: writes above the configuration byte are ignored
    load(9'h140, 8'hAA);
    load(9'h1FF, 8'h07);
    aleIn = 1'b0; addrIn = 8'h40; step();
    check("R10 no alias into array", pat(8'h40), 1'b1);
    addrIn = 8'hFF; step();
    check("R10 no alias into config or array", pat(8'hFF), 1'b1);

    // R2: only bits [2:0] of the configuration byte matter
    load(CFG, 8'hF8);
    aleIn = 1'b0; addrIn = 8'h21; step();
    check("R2 unused config bits ignored", pat(8'h21), 1'b1);

    // R4: latched, active high
    load(CFG, 8'h01);
    aleIn = 1'b1; addrIn = 8'h10; step();
    check("R4 latch open follows address", pat(8'h10), 1'b1);
    aleIn = 1'b0; addrIn = 8'h77; step();
    check("R4 latch closed holds address", pat(8'h10), 1'b1);
    addrIn = 8'h78; step();
    check("R4 latch still holding", pat(8'h10), 1'b1);
    aleIn = 1'b1; step();
    check("R4 latch reopened", pat(8'h78), 1'b1);

    // R5: latched, active low
    load(CFG, 8'h03);
    aleIn = 1'b0; addrIn = 8'h33; step();
    check("R5 low-active latch open", pat(8'h33), 1'b1);
    aleIn = 1'b1; addrIn = 8'h44; step();
    check("R5 low-active latch holds", pat(8'h33), 1'b1);
    aleIn = 1'b0; step();
    check("R5 low-active latch reopened", pat(8'h44), 1'b1);

    // R6: clocked enable
    load(CFG, 8'h04);
    addrIn = 8'h66; enIn = 1'b1; step();
    check("R6 clocked disable", 8'h00, 1'b0);
    enIn = 1'b0; #1;
    check("R6 no change between edges", 8'h00, 1'b0);
    step();
    check("R6 clocked enable at edge", pat(8'h66), 1'b1);
    enIn = 1'b1; #1;
    check("R6 stays on between edges", pat(8'h66), 1'b1);
    step();
    check("R6 clocked disable at edge", 8'h00, 1'b0);

    // R7 R8: combinational enable
    load(CFG, 8'h00);
    enIn = 1'b0; addrIn = 8'h55; step();
    check("R7 combinational enable on", pat(8'h55), 1'b1);
    enIn = 1'b1; #1;
    check("R8 disabled reads zero", 8'h00, 1'b0);
    enIn = 1'b0; #1;
    check("R7 re-enabled without edge", pat(8'h55), 1'b1);

    // R9: reset from clocked mode restores the defaults
    load(CFG, 8'h04);
    enIn = 1'b0; step();
    rst = 1'b1; step();
    check("R9 reset restores combinational mode", 8'h00, 1'b1);
    rst = 1'b0;

    finishRun();
  end

endmodule